// File: doc/BRIEF.md
# Dual-Width Host Memory Port

This block gives a host processor direct access to a word-organised memory array of 2^ADDR_W words, each DATA_W bits wide (1024 by 24 by default). The memory is also used by processing modes that lie outside this block. A 2-bit mode input picks one of three behaviours. In wide mode, each access moves a whole word. In split mode, the host sees each word as a 16-bit low lane and an 8-bit high lane, and a select line chooses between them. In the sync modes, the host port is idle and its write and read enables do nothing.

The enables are active low and are sampled on the system clock. A write takes effect at the sampling edge. Read data is registered twice, once in the array and once at the output. The bidirectional data bus is split into an input, an output and an output enable, so a pad ring or an on-chip mux can build the tristate. A partial write in split mode touches only the selected lane. The array is stored as two independent lane memories, so the other lane keeps its value and no read-modify-write is needed.

Top module: `hp_host_port`

## Requirements
- R1: After synchronous reset, `data_o` is 0 and `data_oe_o` is 0.
- R2: In wide mode (`mode_i` = 2'b01), a write stores `data_i[23:0]` at `addr_i`. A read (`rd_n_i` low, `wr_n_i` high) drives the whole stored word on `data_o`, with `data_oe_o` = 1, two clock edges after the read is sampled.
- R3: In split mode (`mode_i` = 2'b10) with `upper_sel_i` low, a write stores `data_i[15:0]` into bits 15..0 of the addressed word and leaves bits 23..16 unchanged.
- R4: In split mode with `upper_sel_i` high, a write stores `data_i[7:0]` into bits 23..16 of the addressed word and leaves bits 15..0 unchanged.
- R5: A split-mode read with `upper_sel_i` low returns word bits 15..0 on `data_o[15:0]`, with `data_o[23:16]` = 0.
- R6: A split-mode read with `upper_sel_i` high returns word bits 23..16 on `data_o[7:0]`, with `data_o[23:8]` = 0.
- R7: In wide mode, `upper_sel_i` has no effect on writes or reads.
- R8: In the sync modes (`mode_i` = 2'b00 or 2'b11), `wr_n_i` leaves the memory unchanged, and `rd_n_i` low does not raise `data_oe_o`.
- R9: `data_oe_o` is 1 only for a read sampled with `wr_n_i` high. When both enables are low, the write is performed and `data_oe_o` stays 0.
- R10: Whenever `data_oe_o` is 0, `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; enables and data are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00/11 sync (port idle), 01 wide, 10 split |
| addr_i | input | ADDR_W | Word address |
| wr_n_i | input | 1 | Active-low write enable |
| rd_n_i | input | 1 | Active-low read enable |
| upper_sel_i | input | 1 | Split-mode lane select: 0 low 16 bits, 1 high 8 bits |
| data_i | input | DATA_W | Write data from the host |
| data_o | output | DATA_W | Registered read data |
| data_oe_o | output | 1 | Output enable for the data bus |

## Verification
The bench builds the port with ADDR_W = 6 and keeps DATA_W = 24 and the 16/8 lane split. The small address space makes random lane writes and reads land on the same words again and again. This exposes any lane that is clobbered or left stale by an access to the other lane. It also shows whether a sync-mode write leaked into the array.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC     = 2'b00,
    MODE_WIDE     = 2'b01,
    MODE_SPLIT    = 2'b10,
    MODE_SYNC_ALT = 2'b11
  } hp_mode_e;
endpackage

// File: rtl/hp_lane_ram.sv
module hp_lane_ram #(
  parameter int W  = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/hp_decode.sv
module hp_decode
  import hp_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LO_W   = 16
) (
  input  logic [1:0]          mode,
  input  logic                wr_n,
  input  logic                rd_n,
  input  logic                usel,
  input  logic [DATA_W-1:0]   wdata,
  output logic                we_lo,
  output logic                we_hi,
  output logic [LO_W-1:0]     wd_lo,
  output logic [DATA_W-LO_W-1:0] wd_hi,
  output logic                rd_ok,
  output logic                split,
  output logic                usel_eff
);
  localparam int HI_W = DATA_W - LO_W;

  logic wide;
  logic wr_any;

  always_comb begin
    wide     = (hp_mode_e'(mode) == MODE_WIDE);
    split    = (hp_mode_e'(mode) == MODE_SPLIT);
    wr_any   = (wide || split) && !wr_n;
    rd_ok    = (wide || split) && !rd_n && wr_n;
    usel_eff = split && usel;
    we_lo    = wr_any && (wide || !usel);
    we_hi    = wr_any && (wide || usel);
    wd_lo    = wdata[LO_W-1:0];
    wd_hi    = wide ? wdata[DATA_W-1:LO_W] : wdata[HI_W-1:0];
  end
endmodule

// File: rtl/hp_out_fmt.sv
module hp_out_fmt #(
  parameter int DATA_W = 24,
  parameter int LO_W   = 16
) (
  input  logic                   rd,
  input  logic                   split,
  input  logic                   usel,
  input  logic [LO_W-1:0]        lo,
  input  logic [DATA_W-LO_W-1:0] hi,
  output logic [DATA_W-1:0]      word
);
  localparam int HI_W = DATA_W - LO_W;

  always_comb begin
    if (!rd)
      word = '0;
    else if (!split)
      word = {hi, lo};
    else if (usel)
      word = {{LO_W{1'b0}}, hi};
    else
      word = {{HI_W{1'b0}}, lo};
  end
endmodule

// File: rtl/hp_host_port.sv
module hp_host_port #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24,
  parameter int LO_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_n_i,
  input  logic              rd_n_i,
  input  logic              upper_sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int HI_W = DATA_W - LO_W;

  logic            we_lo, we_hi, rd_ok, split, usel_eff;
  logic [LO_W-1:0] wd_lo, q_lo;
  logic [HI_W-1:0] wd_hi, q_hi;
  logic            rd_q, split_q, usel_q;
  logic [DATA_W-1:0] fmt_word;

  hp_decode #(.DATA_W(DATA_W), .LO_W(LO_W)) u_dec (
    .mode(mode_i), .wr_n(wr_n_i), .rd_n(rd_n_i), .usel(upper_sel_i),
    .wdata(data_i), .we_lo(we_lo), .we_hi(we_hi), .wd_lo(wd_lo),
    .wd_hi(wd_hi), .rd_ok(rd_ok), .split(split), .usel_eff(usel_eff)
  );

  hp_lane_ram #(.W(LO_W), .AW(ADDR_W)) u_ram_lo (
    .clk(clk), .we(we_lo), .addr(addr_i), .wdata(wd_lo), .rdata(q_lo)
  );

  hp_lane_ram #(.W(HI_W), .AW(ADDR_W)) u_ram_hi (
    .clk(clk), .we(we_hi), .addr(addr_i), .wdata(wd_hi), .rdata(q_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      split_q <= 1'b0;
      usel_q  <= 1'b0;
    end else begin
      rd_q    <= rd_ok;
      split_q <= split;
      usel_q  <= usel_eff;
    end
  end

  hp_out_fmt #(.DATA_W(DATA_W), .LO_W(LO_W)) u_fmt (
    .rd(rd_q), .split(split_q), .usel(usel_q), .lo(q_lo), .hi(q_hi),
    .word(fmt_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      data_o    <= fmt_word;
      data_oe_o <= rd_q;
    end
  end
endmodule

// File: rtl/hp_host_port_chk.sv
module hp_host_port_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24,
  parameter int LO_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode_i,
  input logic              wr_n_i,
  input logic              rd_n_i,
  input logic              upper_sel_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              we_lo,
  input logic              we_hi
);
  logic [1:0] warm;
  logic       is_async;
  logic       was_split_unused;

  always_comb begin
    is_async         = (mode_i == 2'b01) || (mode_i == 2'b10);
    was_split_unused = |addr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R2
  read_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && $past(is_async && !rd_n_i && wr_n_i, 2)) |-> data_oe_o);

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && $past(!wr_n_i, 2)) |-> !data_oe_o);

  // R8
  sync_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00 || mode_i == 2'b11) |-> !(we_lo || we_hi));

  // R3
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10 && !upper_sel_i) |-> !we_hi);

  // R4
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10 && upper_sel_i) |-> !we_lo);

  // R5
  split_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && $past(mode_i == 2'b10, 2) && data_oe_o)
      |-> (data_o[DATA_W-1:LO_W] == '0));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !data_oe_o |-> (data_o == '0));
endmodule

bind hp_host_port hp_host_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W)
) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .wr_n_i(wr_n_i),
  .rd_n_i(rd_n_i), .upper_sel_i(upper_sel_i), .addr_i(addr_i),
  .data_o(data_o), .data_oe_o(data_oe_o), .we_lo(we_lo), .we_hi(we_hi)
);

// File: tb/tb_hp_host_port.sv
module tb_hp_host_port;
  localparam int AW = 6;
  localparam int DW = 24;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode_i = 2'b00;
  logic [AW-1:0] addr_i = '0;
  logic          wr_n_i = 1'b1;
  logic          rd_n_i = 1'b1;
  logic          upper_sel_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;

  hp_host_port #(.ADDR_W(AW), .DATA_W(DW), .LO_W(16)) dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .addr_i(addr_i),
    .wr_n_i(wr_n_i), .rd_n_i(rd_n_i), .upper_sel_i(upper_sel_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW-1:0] mdl [0:NW-1];
  logic          p_oe  [0:1];
  logic [DW-1:0] p_dat [0:1];
  string         p_tag [0:1];

  function automatic logic [DW-1:0] view(logic [1:0] m, logic us, logic [DW-1:0] w);
    if (m == 2'b01) return w;
    if (us) return {16'h0, w[23:16]};
    return {8'h0, w[15:0]};
  endfunction

  function automatic logic [DW-1:0] store(logic [1:0] m, logic us,
                                          logic [DW-1:0] w, logic [DW-1:0] d);
    if (m == 2'b01) return d;
    if (us) return {d[7:0], w[15:0]};
    return {w[23:16], d[15:0]};
  endfunction

  task automatic check(string tag, logic oe_a, logic oe_e,
                       logic [DW-1:0] d_a, logic [DW-1:0] d_e);
    checks++;
    if (oe_a !== oe_e || d_a !== d_e) begin
      fails++;
      $display("FAIL %s: oe=%0b data=%06h expected oe=%0b data=%06h",
               tag, oe_a, d_a, oe_e, d_e);
    end
  endtask

  task automatic op(logic [1:0] m, logic [AW-1:0] a, logic wn, logic rn,
                    logic us, logic [DW-1:0] d, string tag);
    logic async_m, rdok;
    check(p_tag[1], data_oe_o, p_oe[1], data_o, p_dat[1]);
    p_oe[1]  = p_oe[0];
    p_dat[1] = p_dat[0];
    p_tag[1] = p_tag[0];
    async_m = (m == 2'b01) || (m == 2'b10);
    rdok    = async_m && !rn && wn;
    p_oe[0]  = rdok;
    p_dat[0] = rdok ? view(m, us, mdl[a]) : '0;
    p_tag[0] = tag;
    if (async_m && !wn) mdl[a] = store(m, us, mdl[a], d);
    mode_i = m; addr_i = a; wr_n_i = wn; rd_n_i = rn;
    upper_sel_i = us; data_i = d;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 2; i++) begin
      p_oe[i] = 1'b0; p_dat[i] = '0; p_tag[i] = "R1";
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    check("R1", data_oe_o, 1'b0, data_o, '0);

    // R2: fill every word in wide mode
    for (int i = 0; i < NW; i++)
      op(2'b01, AW'(i), 1'b0, 1'b1, 1'b0, DW'($urandom), "R2");
    for (int i = 0; i < 8; i++)
      op(2'b01, AW'(i * 7), 1'b1, 1'b0, 1'b0, '0, "R2");

    // R3: low-lane write keeps the high lane
    op(2'b10, 6'd5, 1'b0, 1'b1, 1'b0, 24'hABCD12, "R3");
    op(2'b01, 6'd5, 1'b1, 1'b0, 1'b0, '0, "R3");
    // R4: high-lane write keeps the low lane
    op(2'b10, 6'd5, 1'b0, 1'b1, 1'b1, 24'hFFFF5A, "R4");
    op(2'b01, 6'd5, 1'b1, 1'b0, 1'b0, '0, "R4");
    // R5 / R6: lane reads
    op(2'b10, 6'd5, 1'b1, 1'b0, 1'b0, '0, "R5");
    op(2'b10, 6'd5, 1'b1, 1'b0, 1'b1, '0, "R6");
    // R7: select ignored in wide mode
    op(2'b01, 6'd9, 1'b0, 1'b1, 1'b1, 24'h13579B, "R7");
    op(2'b01, 6'd9, 1'b1, 1'b0, 1'b1, '0, "R7");
    // R8: sync modes neither write nor drive
    op(2'b00, 6'd9, 1'b0, 1'b1, 1'b0, 24'h000000, "R8");
    op(2'b11, 6'd9, 1'b0, 1'b1, 1'b1, 24'hFFFFFF, "R8");
    op(2'b00, 6'd9, 1'b1, 1'b0, 1'b0, '0, "R8");
    op(2'b11, 6'd9, 1'b1, 1'b0, 1'b0, '0, "R8");
    op(2'b01, 6'd9, 1'b1, 1'b0, 1'b0, '0, "R8");
    // R9: both enables low, write wins
    op(2'b01, 6'd20, 1'b0, 1'b0, 1'b0, 24'h2468AC, "R9");
    op(2'b10, 6'd20, 1'b0, 1'b0, 1'b1, 24'h0000C3, "R9");
    op(2'b01, 6'd20, 1'b1, 1'b0, 1'b0, '0, "R9");
    // R10: idle cycle drives zero
    op(2'b01, 6'd20, 1'b1, 1'b1, 1'b0, 24'hFFFFFF, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] m;
      logic wn, rn, us;
      string t;
      int sel;
      sel = int'($urandom_range(0, 9));
      m  = (sel < 4) ? 2'b10 : (sel < 8) ? 2'b01 : 2'(sel & 1 ? 3 : 0);
      wn = ($urandom_range(0, 2) != 0);
      rn = ($urandom_range(0, 2) == 0);
      us = 1'($urandom);
      if (m == 2'b00 || m == 2'b11) t = "R8";
      else if (!wn && !rn) t = "R9";
      else if (wn && !rn) t = (m == 2'b01) ? "R7" : (us ? "R6" : "R5");
      else if (!wn) t = (m == 2'b01) ? "R2" : (us ? "R4" : "R3");
      else t = "R10";
      op(m, AW'($urandom), wn, rn, us, DW'($urandom), t);
    end
    op(2'b00, '0, 1'b1, 1'b1, 1'b0, '0, "R10");
    op(2'b00, '0, 1'b1, 1'b1, 1'b0, '0, "R10");
    op(2'b00, '0, 1'b1, 1'b1, 1'b0, '0, "R10");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule